// File: doc/BRIEF.md
# Serial Track-Buffer Readout Slave

This block is the host-facing side of a three-track card-stripe reader. An external controller talks to it as a SPI slave: mode 0, most significant bit first, one 8-bit command per byte. The reply to each command comes out during the byte that follows it. Decoded track bits sit in an external single-bit memory of 3 x TRACK_BYTES x 8 locations. The block fetches those bits itself, packs them into bytes and hands them to the host. Each read reply starts with a status header. Data bytes and a closing XOR check byte follow only when the buffer holds a finished swipe.

The host can stream a whole track, or all three tracks back to back, just by clocking NoOps. It can also pull one byte per "continue" command. A successful read opens an exclusive transaction, signalled on `host_lock`, which the swipe decoder uses to hold off new swipes. Only the arm/flush command closes the transaction. That command also raises a one-cycle erase request to the memory. Protocol misuse is recorded in two sticky header flags. A timer resets the bit counter after a long pause on the serial clock, so a host that ties chip select low can re-align.

All serial inputs are sampled with the system clock through two-stage synchronizers. The serial clock must therefore stay slow compared with `clk`. Each half period of the serial clock must be at least 6 `clk` cycles.

Top module: `trk_spi_readout`

## Requirements
- R1: MOSI is taken on each rising serial-clock edge, MSB first. MISO shifts on the falling edges and carries tx bit 7 at all times. The reply to a command is the byte shifted out during the following byte. The first byte after chip select falls returns 0xFF. `spi_miso_en` is low whenever chip select is high.
- R2: Command 0x06 returns the header. Header bit 0 is busy (`swipe_busy` or `erase_busy`). Bit 1 is empty (`buf_has_data` low). Bit 2 is power-on. Bit 6 is invalid-command. Bit 7 is out-of-order. Bits 3 to 5 are zero. Loading a header clears the power-on, invalid and out-of-order flags.
- R3: A read command (0x01 to 0x04, 0x11 to 0x14) seen while busy or empty returns only the header and opens no transaction. Every later byte returns 0xFF.
- R4: Commands 0x01, 0x02 and 0x03 select track t. The reply is the header, then TRACK_BYTES data bytes built from the memory bits starting at address (t-1) x TRACK_BYTES x 8, with the lowest address in bit 7. Command 0x04 covers all three tracks from address 0. The data bytes go out one per byte regardless of the command received, except 0x05 and 0x16. Then comes the check byte, then 0xFF.
- R5: The check byte equals the XOR of every data byte sent since the read command.
- R6: Commands 0x11 to 0x14 return the header. Each 0x15 then returns the next data byte, and a NoOp during the data phase returns 0xFF without advancing. After the last data byte, the next command returns the check byte; if that command is 0x15, out-of-order is set. Any 0x15 while no byte read is pending returns 0xFF and sets out-of-order.
- R7: A read or status command received during a data or check-byte phase is ignored and sets out-of-order. A read command received while a transaction is open is ignored and sets out-of-order. No error is set when the command arrives during the byte in which the header is shifted out.
- R8: Any opcode other than 0x00-0x06, 0x11-0x16 and 0xFF sets invalid-command and returns 0xFF.
- R9: Command 0x05 returns 0x05, pulses `erase_start` for exactly one cycle, clears invalid and out-of-order, ends any read and releases `host_lock`.
- R10: Command 0x16 ends a read early, returns 0xFF and sets no error flag.
- R11: Raising chip select aborts any read, clears invalid and out-of-order and restarts the bit count.
- R12: TMO_CYCLES clock cycles with no serial-clock edge reset the bit counter, so the next eight bits form a whole command.
- R13: `host_lock` rises when a read starts on a non-busy, non-empty buffer and falls only on command 0x05.
- R14: After reset, power-on is set, `spi_miso_en`, `erase_start`, `host_lock` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial command data from the host |
| spi_miso | output | 1 | Serial reply data |
| spi_miso_en | output | 1 | Output enable for the MISO pad driver |
| swipe_busy | input | 1 | A swipe is being decoded into the buffer |
| erase_busy | input | 1 | The buffer is being erased |
| buf_has_data | input | 1 | The buffer holds a finished swipe |
| erase_start | output | 1 | One-cycle request to erase the buffer |
| host_lock | output | 1 | Host transaction open; swipes must be ignored |
| mem_rd | output | 1 | Bit memory read strobe |
| mem_addr | output | $clog2(24*TRACK_BYTES) | Bit memory read address |
| mem_bit | input | 1 | Read data, valid the cycle after `mem_rd` |

## Verification
Most internal mistakes show up in the reply byte one serial byte after the command that triggers them. Examples are a wrong state transition, a lost header window or a misdirected prefetch address, each of which puts the wrong byte where a header or data byte was due. Flag mistakes are hidden until the next status header, so the bench follows each error-provoking stimulus with a status read. The check byte reports any data corruption only at the end of a stream. The bench therefore compares it against an XOR computed from the expected data. A wrong bit counter after chip-select edges or a timeout misaligns every later command, so the first status reply after the event exposes it.

// File: rtl/trk_spi_readout.sv
module trk_spi_readout #(
  parameter int TRACK_BYTES = 96,
  parameter int TMO_CYCLES  = 8_000_000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 spi_sck,
  input  logic                                 spi_csn,
  input  logic                                 spi_mosi,
  output logic                                 spi_miso,
  output logic                                 spi_miso_en,
  input  logic                                 swipe_busy,
  input  logic                                 erase_busy,
  input  logic                                 buf_has_data,
  output logic                                 erase_start,
  output logic                                 host_lock,
  output logic                                 mem_rd,
  output logic [$clog2(24*TRACK_BYTES)-1:0]    mem_addr,
  input  logic                                 mem_bit
);
  localparam int TRACK_BITS = TRACK_BYTES * 8;
  localparam int ALL_BYTES  = 3 * TRACK_BYTES;
  localparam int TOTAL_BITS = ALL_BYTES * 8;
  localparam int AW = $clog2(TOTAL_BITS);
  localparam int BW = $clog2(ALL_BYTES + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_BDATA, S_BLRC} st_t;

  logic [2:0] sck_q, csn_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; csn_q <= '1; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], spi_sck};
      csn_q <= {csn_q[1:0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  logic sck_rise, sck_fall, cs_on, cs_begin, cs_end;
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_on    = ~csn_q[1];
  assign cs_begin = ~csn_q[1] & csn_q[2];
  assign cs_end   = csn_q[1] & ~csn_q[2];

  logic [TW-1:0] tmo_cnt;
  logic tmo_fire;
  assign tmo_fire = (tmo_cnt == TW'(TMO_CYCLES - 1)) & ~(sck_rise | sck_fall);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (sck_rise | sck_fall) tmo_cnt <= '0;
    else if (tmo_cnt != TW'(TMO_CYCLES)) tmo_cnt <= tmo_cnt + 1'b1;

  logic [2:0] bitcnt;
  logic [6:0] rx;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; rx <= '0;
    end else if (cs_begin | cs_end | tmo_fire) begin
      bitcnt <= '0;
    end else if (sck_rise & cs_on) begin
      bitcnt <= bitcnt + 1'b1;
      rx <= {rx[5:0], mosi_q[1]};
    end

  logic byte_done;
  logic [7:0] cmd;
  assign byte_done = sck_rise & cs_on & (bitcnt == 3'd7);
  assign cmd = {rx, mosi_q[1]};

  logic is_seq, is_byt, is_stat, is_arm, is_eoc, is_cont, is_nop, is_bad;
  assign is_seq  = (cmd >= 8'h01) && (cmd <= 8'h04);
  assign is_byt  = (cmd >= 8'h11) && (cmd <= 8'h14);
  assign is_stat = cmd == 8'h06;
  assign is_arm  = cmd == 8'h05;
  assign is_eoc  = cmd == 8'h16;
  assign is_cont = cmd == 8'h15;
  assign is_nop  = (cmd == 8'h00) || (cmd == 8'hFF);
  assign is_bad  = ~(is_seq | is_byt | is_stat | is_arm | is_eoc | is_cont | is_nop);

  st_t st, n_st;
  logic win, n_win, f_por, f_inv, f_ooo;
  logic [BW-1:0] idx, len;
  logic [7:0] lrc, pf_byte, tx, n_tx, hdr_byte;
  logic hdr_busy, hdr_empty;
  logic do_hdr, do_eat, do_lrc, set_ooo, go;

  assign hdr_busy  = swipe_busy | erase_busy;
  assign hdr_empty = ~buf_has_data;
  assign hdr_byte  = {f_ooo, f_inv, 3'b000, f_por, hdr_empty, hdr_busy};

  logic [AW-1:0] rd_start;
  logic [BW-1:0] rd_len;
  assign rd_start = (cmd[2:0] == 3'd4) ? '0 : AW'(TRACK_BITS * (int'(cmd[2:0]) - 1));
  assign rd_len   = (cmd[2:0] == 3'd4) ? BW'(ALL_BYTES) : BW'(TRACK_BYTES);

  always_comb begin
    n_st = st; n_win = 1'b0;
    do_hdr = 1'b0; do_eat = 1'b0; do_lrc = 1'b0; set_ooo = 1'b0; go = 1'b0;
    if (is_arm || is_eoc) begin
      n_st = S_IDLE;
    end else begin
      if (st != S_IDLE && (is_seq || is_byt || is_stat) && !win) set_ooo = 1'b1;
      case (st)
        S_IDLE:
          if (is_stat) do_hdr = 1'b1;
          else if (is_seq || is_byt) begin
            if (host_lock) set_ooo = 1'b1;
            else begin
              do_hdr = 1'b1;
              if (!hdr_busy && !hdr_empty) begin
                go = 1'b1; n_win = 1'b1;
                n_st = is_seq ? S_SEQ : S_BDATA;
              end
            end
          end else if (is_cont) set_ooo = 1'b1;
        S_SEQ: begin
          if (is_cont) set_ooo = 1'b1;
          if (idx != len) do_eat = 1'b1;
          else begin do_lrc = 1'b1; n_st = S_IDLE; end
        end
        S_BDATA:
          if (is_cont) begin
            do_eat = 1'b1;
            if (idx == len - BW'(1)) n_st = S_BLRC;
          end
        S_BLRC: begin
          if (is_cont) set_ooo = 1'b1;
          do_lrc = 1'b1; n_st = S_IDLE;
        end
        default: n_st = S_IDLE;
      endcase
    end
    n_tx = is_arm ? 8'h05 : do_hdr ? hdr_byte : do_eat ? pf_byte : do_lrc ? lrc : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; win <= 1'b0; f_por <= 1'b1; f_inv <= 1'b0; f_ooo <= 1'b0;
      host_lock <= 1'b0; idx <= '0; len <= '0; lrc <= '0;
    end else if (cs_end) begin
      st <= S_IDLE; win <= 1'b0; f_inv <= 1'b0; f_ooo <= 1'b0;
    end else if (byte_done) begin
      st <= n_st; win <= n_win;
      if (is_arm) begin
        f_inv <= 1'b0; f_ooo <= 1'b0; host_lock <= 1'b0;
      end else if (do_hdr) begin
        f_inv <= 1'b0; f_ooo <= 1'b0; f_por <= 1'b0;
      end else begin
        f_inv <= f_inv | is_bad; f_ooo <= f_ooo | set_ooo;
      end
      if (go) begin
        host_lock <= 1'b1; len <= rd_len; idx <= '0; lrc <= '0;
      end
      if (do_eat) begin
        idx <= idx + 1'b1; lrc <= lrc ^ pf_byte;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) erase_start <= 1'b0;
    else erase_start <= byte_done & is_arm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx <= 8'hFF;
    else if (cs_begin) tx <= 8'hFF;
    else if (byte_done) tx <= n_tx;
    else if (sck_fall && cs_on && bitcnt != 3'd0) tx <= {tx[6:0], 1'b1};

  assign spi_miso = tx[7];
  assign spi_miso_en = cs_on;

  logic [AW-1:0] pf_addr;
  logic [BW-1:0] pf_left;
  logic [2:0] pf_cnt;
  logic pf_valid, pf_pend;
  assign mem_rd = ~pf_valid & (pf_left != '0) & ~pf_pend;
  assign mem_addr = pf_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_addr <= '0; pf_left <= '0; pf_cnt <= '0; pf_valid <= 1'b0; pf_pend <= 1'b0;
      pf_byte <= 8'hFF;
    end else if (byte_done && go) begin
      pf_addr <= rd_start; pf_left <= rd_len; pf_cnt <= '0;
      pf_valid <= 1'b0; pf_pend <= 1'b0;
    end else begin
      if (byte_done && do_eat) pf_valid <= 1'b0;
      if (pf_pend) begin
        pf_byte <= {pf_byte[6:0], mem_bit};
        pf_addr <= pf_addr + 1'b1;
        pf_pend <= 1'b0;
        pf_cnt <= pf_cnt + 1'b1;
        if (pf_cnt == 3'd7) begin
          pf_valid <= 1'b1; pf_left <= pf_left - 1'b1;
        end
      end else if (mem_rd) pf_pend <= 1'b1;
    end

  p_erase_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  p_lock_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_lock) |-> $past(byte_done && is_arm));
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (int'(mem_addr) < TOTAL_BITS));
  p_cs_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (st == S_IDLE && !f_inv && !f_ooo && bitcnt == 3'd0));
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len);
  p_stream_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> host_lock);
endmodule

// File: tb/tb_trk_spi_readout.sv
module tb_trk_spi_readout;
  localparam int TB = 4;
  localparam int TMO = 300;
  localparam int H = 8;
  localparam int AW = $clog2(24 * TB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_en, erase_start, host_lock, mem_rd, mem_bit = 1'b0;
  logic swipe_busy = 1'b0, erase_busy = 1'b0, has_data = 1'b0;
  logic [AW-1:0] mem_addr;
  int n_run = 0, n_fail = 0, er_cnt = 0;
  logic [7:0] r;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trk_spi_readout #(.TRACK_BYTES(TB), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .swipe_busy(swipe_busy),
    .erase_busy(erase_busy), .buf_has_data(has_data), .erase_start(erase_start),
    .host_lock(host_lock), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_bit(mem_bit));

  function automatic logic [7:0] bval(int g);
    return 8'((g * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      automatic logic [7:0] v = bval(int'(mem_addr) / 8);
      mem_bit <= v[3'(7 - int'(mem_addr) % 8)];
    end
    if (erase_start) er_cnt <= er_cnt + 1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic x(input logic [7:0] o);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      tick(H);
      r[b] = miso;
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    csn = 1'b0; tick(H);
  endtask

  task automatic desel();
    tick(H); csn = 1'b1; tick(4 * H);
  endtask

  task automatic arm();
    x(8'h05); x(8'hFF); chk("R9 arm reply", r, 8'h05);
  endtask

  initial begin
    logic [7:0] l;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R14 reset outputs", {4'h0, miso_en, erase_start, host_lock, mem_rd}, 8'h00);

    sel();
    chk("R1 miso enabled", {7'h0, miso_en}, 8'h01);
    x(8'h06); chk("R1 first byte", r, 8'hFF);
    x(8'hFF); chk("R2 R14 header por empty", r, 8'h06);
    x(8'h06); chk("R2 nop reply", r, 8'hFF);
    x(8'hFF); chk("R2 por cleared", r, 8'h02);

    has_data = 1'b1; swipe_busy = 1'b1;
    x(8'h01); x(8'hFF); chk("R3 busy header", r, 8'h01);
    x(8'hFF); chk("R3 no data", r, 8'hFF);
    chk("R3 no lock", {7'h0, host_lock}, 8'h00);
    swipe_busy = 1'b0;

    x(8'h02); x(8'hFF); chk("R4 header", r, 8'h00);
    l = 8'h00;
    for (int j = 0; j < TB; j++) begin
      x(8'hFF); chk("R4 track2 data", r, bval(TB + j)); l ^= bval(TB + j);
    end
    x(8'hFF); chk("R5 lrc", r, l);
    x(8'hFF); chk("R4 trailing ff", r, 8'hFF);
    chk("R13 lock held", {7'h0, host_lock}, 8'h01);
    x(8'h06); x(8'hFF); chk("R2 status after stream", r, 8'h00);

    x(8'h01); x(8'hFF); chk("R7 read in transaction ignored", r, 8'hFF);
    x(8'h06); x(8'hFF); chk("R7 ooo flag", r, 8'h80);

    arm();
    chk("R9 erase pulse", 8'(er_cnt), 8'h01);
    chk("R13 lock released", {7'h0, host_lock}, 8'h00);
    erase_busy = 1'b1;
    x(8'h06); x(8'hFF); chk("R2 erase busy", r, 8'h01);
    erase_busy = 1'b0;

    x(8'h42); x(8'h06); chk("R8 unknown reply", r, 8'hFF);
    x(8'hFF); chk("R8 inv flag", r, 8'h40);

    x(8'h15); x(8'h06); x(8'hFF); chk("R6 idle continue ooo", r, 8'h80);

    x(8'h14); x(8'h15); chk("R6 byte header", r, 8'h00);
    x(8'h15); chk("R6 byte0", r, bval(0));
    x(8'hFF); chk("R6 byte1", r, bval(1));
    x(8'h15); chk("R6 nop no advance", r, 8'hFF);
    l = bval(0) ^ bval(1);
    for (int j = 2; j < 3 * TB; j++) begin
      x(8'h15); chk("R6 byte data", r, bval(j)); l ^= bval(j);
    end
    x(8'h15); chk("R6 R5 lrc on extra continue", r, l);
    x(8'h15); chk("R6 after lrc", r, 8'hFF);
    x(8'h06); x(8'hFF); chk("R6 ooo set", r, 8'h80);
    arm();

    x(8'h04); x(8'hFF); chk("R10 header", r, 8'h00);
    x(8'hFF); chk("R10 data0", r, bval(0));
    x(8'h16); chk("R10 data1", r, bval(1));
    x(8'hFF); chk("R10 eoc reply", r, 8'hFF);
    x(8'h06); chk("R10 stream stopped", r, 8'hFF);
    x(8'hFF); chk("R10 no error", r, 8'h00);
    arm();

    x(8'h03); x(8'h06); chk("R7 header window", r, 8'h00);
    x(8'h01); chk("R7 data0", r, bval(2 * TB));
    l = bval(2 * TB);
    for (int j = 1; j < TB; j++) begin
      x(8'hFF); chk("R7 data continues", r, bval(2 * TB + j)); l ^= bval(2 * TB + j);
    end
    x(8'hFF); chk("R5 track3 lrc", r, l);
    x(8'h06); x(8'hFF); chk("R7 mid read ooo only", r, 8'h80);
    arm();

    x(8'h42);
    desel();
    chk("R1 miso off", {7'h0, miso_en}, 8'h00);
    sel();
    x(8'h06); chk("R11 first byte", r, 8'hFF);
    x(8'hFF); chk("R11 errors cleared", r, 8'h00);
    x(8'h11); desel(); sel();
    x(8'h15); x(8'h06); x(8'hFF); chk("R11 byte read aborted", r, 8'h80);
    arm();

    for (int b = 0; b < 3; b++) begin
      mosi = 1'b1; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
    end
    tick(TMO + 50);
    x(8'h06); x(8'hFF); chk("R12 realigned after timeout", r, 8'h00);
    desel();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule